// File: doc/BRIEF.md
# Configuration Header Sync Detector

This block watches an incoming byte stream for the 13-word preamble that opens a configuration bitstream. The search runs at every byte position, not only at word boundaries. While it runs, the block also decides whether the stream carries its 32-bit words with the first byte as the most significant or as the least significant byte. Once the preamble is found, it raises a sticky found flag and a byte-order flag. It also reports the byte position where the preamble began. From then on, every four accepted bytes leave as one 32-bit word with the detected order applied.

The last 52 bytes are held in a sliding window. When the window is full and its contents do not form the preamble, the oldest byte is dropped and the next position is tried. No input is lost, and a partial match that fails is rescanned from the following byte. An abort input returns the block to its power-up search state at any time.

The preamble, in the order the words arrive, is: eight all-ones filler words, then 0x000000BB, then 0x11220044, then two more filler words, then 0xAA995566. Filler words read the same in either byte order, so they play no part in the order decision.

Top module: `bsd_sync_detect`

## Requirements
- R1: After reset, `found`, `swapped`, `out_valid` and `hdr_offset` are 0 and `in_ready` is 1.
- R2: When the preamble arrives with each word sent most significant byte first, `found` becomes 1 and `swapped` stays 0.
- R3: `hdr_offset` gives the number of bytes accepted since reset or abort that came before the first byte of the matched preamble. The position can be any byte, not only a multiple of four.
- R4: The byte order is decided only by preamble word 8 (0x000000BB). If its bytes arrive as BB,00,00,00, the block enters swapped mode and `swapped` reads 1 once found. All-ones filler words never set swapped mode.
- R5: Once word 8 has fixed the order, words 9 and 12 must match in that same order. If either is wrong, the position is rejected, the search moves on by one byte, and `found` stays 0.
- R6: After `found`, every fourth accepted byte produces a one-cycle `out_valid` pulse with `out_word`. In normal order the first of the four bytes is placed in bits [31:24]. In swapped mode it is placed in bits [7:0].
- R7: When `abort` is high, `in_ready` is 0 and the input byte is not taken. On the next clock `found`, `swapped` and `hdr_offset` return to 0 and the window is emptied.
- R8: `out_valid` never pulses while the block is searching, that is, before `found` or after an abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort | input | 1 | Return to the search state and clear all flags |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Block takes the byte on this edge if valid |
| in_data | input | 8 | Input byte |
| found | output | 1 | Preamble has been matched (sticky until abort) |
| swapped | output | 1 | Matched preamble was in reversed byte order |
| hdr_offset | output | OFF_W | Byte position of the preamble start |
| out_valid | output | 1 | One-cycle strobe for `out_word` |
| out_word | output | 32 | Payload word with the byte order applied |

## Verification
The bench builds the block with the default 32-bit offset width. The window depth is fixed at 52 bytes by the preamble length.

With these values, the bench can reach a preamble that starts at an odd byte position after a few bytes of noise. It can also reach a preamble that follows a false start of 36 bytes, which shares eight filler words with the real one. A third case is a preamble whose tail words come in the wrong order after word 8 has fixed the order; this one must be rejected.

Payload words are gathered by a monitor. They are compared in both byte orders, and again after an abort in the middle of the payload.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
    localparam int HDR_WORDS = 13;
    localparam int WIN_BYTES = HDR_WORDS * 4;
    localparam int ORDER_WORD = 8;

    function automatic logic [31:0] hdr_word(input int idx);
        case (idx)
            8:       hdr_word = 32'h0000_00BB;
            9:       hdr_word = 32'h1122_0044;
            12:      hdr_word = 32'hAA99_5566;
            default: hdr_word = 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] rev_bytes(input logic [31:0] w);
        rev_bytes = {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction
endpackage

// File: rtl/bsd_window.sv
module bsd_window #(
    parameter int DEPTH = 52,
    parameter int OFF_W = 32,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               push,
    input  logic [7:0]         push_byte,
    input  logic               drop,
    output logic [DEPTH*8-1:0] bytes,
    output logic               full,
    output logic [OFF_W-1:0]   offset
);
    typedef struct packed {
        logic [DEPTH-1:0][7:0] buf_b;
        logic [CNT_W-1:0]      cnt;
        logic [OFF_W-1:0]      off;
    } win_t;

    win_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else begin
            if (drop) begin
                for (int i = 0; i < DEPTH - 1; i++) begin
                    st_d.buf_b[i] = st_q.buf_b[i + 1];
                end
                st_d.buf_b[DEPTH-1] = 8'h00;
                st_d.cnt = st_q.cnt - 1'b1;
                st_d.off = st_q.off + 1'b1;
            end
            if (push) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (CNT_W'(i) == st_d.cnt) begin
                        st_d.buf_b[i] = push_byte;
                    end
                end
                st_d.cnt = st_d.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bytes  = st_q.buf_b;
    assign full   = (st_q.cnt == CNT_W'(DEPTH));
    assign offset = st_q.off;

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    a_r3_offset_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !clear) |=> (st_q.off == $past(st_q.off) + 1'b1));
endmodule

// File: rtl/bsd_matcher.sv
module bsd_matcher
    import bsd_pkg::*;
(
    input  logic [WIN_BYTES*8-1:0] bytes,
    output logic                   match,
    output logic                   swap
);
    logic [HDR_WORDS-1:0] word_ok;
    logic [31:0]          raw_order;

    assign raw_order = {bytes[(4*ORDER_WORD)*8 +: 8], bytes[(4*ORDER_WORD+1)*8 +: 8],
                        bytes[(4*ORDER_WORD+2)*8 +: 8], bytes[(4*ORDER_WORD+3)*8 +: 8]};
    assign swap = (rev_bytes(raw_order) == hdr_word(ORDER_WORD));

    for (genvar g = 0; g < HDR_WORDS; g++) begin : g_word
        logic [31:0] raw;
        logic [31:0] cmp;
        assign raw = {bytes[(4*g)*8 +: 8], bytes[(4*g+1)*8 +: 8],
                      bytes[(4*g+2)*8 +: 8], bytes[(4*g+3)*8 +: 8]};
        assign cmp = swap ? rev_bytes(raw) : raw;
        assign word_ok[g] = (cmp == hdr_word(g));
    end

    assign match = &word_ok;
endmodule

// File: rtl/bsd_packer.sv
module bsd_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clear,
    input  logic        en,
    input  logic [7:0]  byte_in,
    input  logic        swap,
    output logic        out_valid,
    output logic [31:0] out_word
);
    typedef struct packed {
        logic [1:0]  cnt;
        logic [23:0] acc;
        logic        valid;
        logic [31:0] word;
    } pk_t;

    pk_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.valid = 1'b0;
        if (clear) begin
            st_d = '0;
        end else if (en) begin
            if (st_q.cnt == 2'd3) begin
                st_d.word  = swap ? {byte_in, st_q.acc[7:0], st_q.acc[15:8], st_q.acc[23:16]}
                                  : {st_q.acc, byte_in};
                st_d.valid = 1'b1;
                st_d.cnt   = 2'd0;
            end else begin
                st_d.acc = {st_q.acc[15:0], byte_in};
                st_d.cnt = st_q.cnt + 2'd1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_word  = st_q.word;

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);
endmodule

// File: rtl/bsd_sync_detect.sv
module bsd_sync_detect
    import bsd_pkg::*;
#(
    parameter int OFF_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             abort,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             found,
    output logic             swapped,
    output logic [OFF_W-1:0] hdr_offset,
    output logic             out_valid,
    output logic [31:0]      out_word
);
    typedef struct packed {
        logic found;
        logic swapped;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [WIN_BYTES*8-1:0] win_bytes;
    logic win_full, hit, hit_swap;
    logic take, win_push, win_drop, pk_en;

    always_comb begin
        in_ready = !abort && (ctl_q.found || !(win_full && hit));
        take     = in_valid && in_ready;
        win_push = take && !ctl_q.found;
        win_drop = !abort && !ctl_q.found && win_full && !hit;
        pk_en    = take && ctl_q.found;

        ctl_d = ctl_q;
        if (abort) begin
            ctl_d = '0;
        end else if (!ctl_q.found && win_full && hit) begin
            ctl_d.found   = 1'b1;
            ctl_d.swapped = hit_swap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    bsd_window #(.DEPTH(WIN_BYTES), .OFF_W(OFF_W)) u_win (
        .clk(clk), .rst_n(rst_n), .clear(abort),
        .push(win_push), .push_byte(in_data), .drop(win_drop),
        .bytes(win_bytes), .full(win_full), .offset(hdr_offset)
    );

    bsd_matcher u_match (
        .bytes(win_bytes), .match(hit), .swap(hit_swap)
    );

    bsd_packer u_pack (
        .clk(clk), .rst_n(rst_n), .clear(abort), .en(pk_en),
        .byte_in(in_data), .swap(ctl_q.swapped),
        .out_valid(out_valid), .out_word(out_word)
    );

    assign found   = ctl_q.found;
    assign swapped = ctl_q.swapped;

    a_r2_found_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !abort) |=> found);

    a_r3_offset_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (found && !abort) |=> $stable(hdr_offset));

    a_r7_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!found && !swapped && !out_valid));

    a_r8_no_word_in_search: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> found);
endmodule

// File: tb/bsd_sync_detect_test.sv
`timescale 1ns/1ps
module bsd_sync_detect_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        abort = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready, found, swapped, out_valid;
    logic [31:0] hdr_offset, out_word;

    int n_chk = 0;
    int n_bad = 0;
    int n_words = 0;
    logic [31:0] words [0:63];

    always #4 clk = ~clk;

    bsd_sync_detect #(.OFF_W(32)) uut (
        .clk(clk), .rst_n(rst_n), .abort(abort),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .found(found), .swapped(swapped), .hdr_offset(hdr_offset),
        .out_valid(out_valid), .out_word(out_word)
    );

    always @(negedge clk) begin
        if (out_valid) begin
            if (n_words < 64) words[n_words] <= out_word;
            n_words <= n_words + 1;
        end
    end

    function automatic logic [31:0] pat(input int i);
        if (i == 8)       pat = 32'h0000_00BB;
        else if (i == 9)  pat = 32'h1122_0044;
        else if (i == 12) pat = 32'hAA99_5566;
        else              pat = 32'hFFFF_FFFF;
    endfunction

    function automatic logic [31:0] flip(input logic [31:0] w);
        flip = {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic send_word(input logic [31:0] w);
        for (int k = 3; k >= 0; k--) send_byte(w[k*8 +: 8]);
    endtask

    task automatic send_hdr(input bit rev);
        for (int i = 0; i < 13; i++) send_word(rev ? flip(pat(i)) : pat(i));
    endtask

    task automatic do_abort();
        @(negedge clk);
        abort = 1'b1;
        #1;
        chk(in_ready == 1'b0, "R7 ready low in abort", 32'(in_ready), 32'd0);
        @(posedge clk);
        #1;
        abort = 1'b0;
        @(negedge clk);
        chk(found == 1'b0 && swapped == 1'b0, "R7 flags cleared", {30'd0, found, swapped}, 32'd0);
        chk(hdr_offset == 32'd0, "R7 offset cleared", hdr_offset, 32'd0);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(found == 1'b0, "R1 found", 32'(found), 32'd0);
        chk(swapped == 1'b0, "R1 swapped", 32'(swapped), 32'd0);
        chk(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
        chk(hdr_offset == 32'd0, "R1 offset", hdr_offset, 32'd0);
        chk(in_ready == 1'b1, "R1 in_ready", 32'(in_ready), 32'd1);
    endtask

    task automatic t_direct();
        int base;
        send_hdr(1'b0);
        idle(2);
        chk(found == 1'b1, "R2 found direct", 32'(found), 32'd1);
        chk(swapped == 1'b0, "R2 not swapped", 32'(swapped), 32'd0);
        chk(hdr_offset == 32'd0, "R3 offset zero", hdr_offset, 32'd0);
        base = n_words;
        send_word(32'hDEAD_BEEF);
        send_word(32'h0102_0304);
        idle(3);
        chk(n_words == base + 2, "R6 word count direct", 32'(n_words - base), 32'd2);
        chk(words[base] == 32'hDEAD_BEEF, "R6 direct word0", words[base], 32'hDEAD_BEEF);
        chk(words[base+1] == 32'h0102_0304, "R6 direct word1", words[base+1], 32'h0102_0304);
    endtask

    task automatic t_swapped_odd();
        int base;
        do_abort();
        for (int k = 1; k <= 5; k++) send_byte(8'(k));
        base = n_words;
        send_hdr(1'b1);
        idle(2);
        chk(n_words == base, "R8 no word during search", 32'(n_words - base), 32'd0);
        chk(found == 1'b1, "R4 found swapped", 32'(found), 32'd1);
        chk(swapped == 1'b1, "R4 swapped flag", 32'(swapped), 32'd1);
        chk(hdr_offset == 32'd5, "R3 odd offset", hdr_offset, 32'd5);
        base = n_words;
        send_word(32'hDEAD_BEEF);
        idle(3);
        chk(n_words == base + 1 && words[base] == 32'hEFBE_ADDE, "R6 swapped word",
            words[base], 32'hEFBE_ADDE);
    endtask

    task automatic t_abort_payload();
        int base;
        do_abort();
        base = n_words;
        send_word(32'h5566_7788);
        send_word(32'h99AA_BBCC);
        idle(3);
        chk(n_words == base, "R8 no word after abort", 32'(n_words - base), 32'd0);
        chk(found == 1'b0, "R8 still searching", 32'(found), 32'd0);
    endtask

    task automatic t_false_start();
        do_abort();
        for (int i = 0; i < 8; i++) send_word(32'hFFFF_FFFF);
        send_word(32'h1234_5678);
        send_hdr(1'b0);
        idle(2);
        chk(found == 1'b1, "R5 found after false start", 32'(found), 32'd1);
        chk(hdr_offset == 32'd36, "R3 offset after false start", hdr_offset, 32'd36);
        chk(swapped == 1'b0, "R4 fillers never swap", 32'(swapped), 32'd0);
    endtask

    task automatic t_mixed_reject();
        do_abort();
        for (int i = 0; i < 13; i++) send_word(i == 9 ? flip(pat(i)) : pat(i));
        idle(60);
        chk(found == 1'b0, "R5 mixed order word9 rejected", 32'(found), 32'd0);
        do_abort();
        for (int i = 0; i < 13; i++) send_word(i == 12 ? pat(i) : flip(pat(i)));
        idle(60);
        chk(found == 1'b0, "R5 mixed order word12 rejected", 32'(found), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_swapped_odd();
        t_abort_payload();
        t_false_start();
        t_mixed_reject();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #1000000;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad + 1);
        $finish;
    end
endmodule